// File: doc/BRIEF.md
# Coincidence Window Evaluator with Per-Channel Arrival Timing

This block watches the hit lines of up to eight detector channels. The first rising edge on any enabled channel opens a coincidence window whose length is a programmable number of clock cycles. While the window is open the block records three things for each channel: whether it fired, how many rising edges it accepted, and the number of cycles from the opening of the window to its first accepted edge.

When the window closes, the vector of channels that fired is judged against a per-channel requirement. A channel can be marked as one that must fire, one that must stay silent, or one that does not matter. The block then raises a one-cycle result strobe with a pass/fail flag. The captured hitmap, delays and counts stay on the outputs until the next window opens.

The block does not accept new hits after the result until an external rearm input is asserted. This lets the surrounding logic collect the data and run any output or handshake sequence first.

Top module: `coinc_window_eval`

## Requirements
- R1: A rising edge on an enabled channel, seen while the block is idle, opens a window, and `busy_o` is high from the next cycle. Edges on channels whose `enable_i` bit is 0 never open a window, never count and never set a hitmap bit.
- R2: Call the clock edge that samples the opening hit cycle 0, and let L be `win_len_i`, with 0 taken as 1. Hits sampled at cycles 0 to L-1 are accepted and hits at cycle L are not. `done_o` is high for the one cycle that follows clock edge L.
- R3: For a channel that fired, `delay_o[16*i +: 16]` holds the cycle index of its first accepted edge, so a channel that opens the window reads 0. For a channel that did not fire it holds L. The counter saturates at all ones rather than wrapping.
- R4: The requirement code for channel i is `req_i[2*i +: 2]`: 2'b01 means the channel must have fired, 2'b10 means it must not have fired, and 2'b00 or 2'b11 means the channel is ignored. `valid_o` is high with `done_o` exactly when every channel meets its code.
- R5: An enabled channel coded as ignored still opens the window and is still recorded in the hitmap, delays and counts, but it does not change `valid_o`.
- R6: Bit i of `hitmap_o` is channel i+1, so channel 8 is the MSB and channel 1 is the LSB.
- R7: `count_o[8*i +: 8]` counts the rising edges channel i had accepted in the window, including the opening edge. The count saturates at 255.
- R8: `done_o` lasts one cycle, `valid_o` is never high without `done_o`, and `busy_o` is high through the open window and the result cycle and low afterwards. The hitmap, delays and counts are held unchanged until the next window opens.
- R9: After `done_o`, no edge opens a window until `rearm_i` is sampled high while the block is waiting. A rearm given while the window is still open or being judged has no effect.
- R10: Only a 0-to-1 transition of a hit line counts as an edge. A line held high counts once, and a line that is already high when the block rearms does not open a window.
- R11: `win_len_i` and `req_i` are captured when the window opens, so changing them while the window is open does not alter its length or its verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_i | input | 8 | Hit lines, bit i is channel i+1 |
| enable_i | input | 8 | Per-channel enable |
| req_i | input | 16 | Two-bit requirement code per channel |
| win_len_i | input | 16 | Window length in cycles (0 acts as 1) |
| rearm_i | input | 1 | Lets the block accept a new window after a result |
| busy_o | output | 1 | Window open or result being produced |
| done_o | output | 1 | One-cycle result strobe |
| valid_o | output | 1 | Requirement met, qualified by done_o |
| hitmap_o | output | 8 | Channels that fired in the window |
| delay_o | output | 128 | Per-channel first-hit delay, 16 bits each |
| count_o | output | 64 | Per-channel accepted edge count, 8 bits each |

## Verification
The two functions that can fall in the same cycle are the acceptance of a channel's hit and the closing of the window. The bench provokes this by placing one channel's edge at index L-1 and another's at index L of the same window. It judges the result by requiring the first channel to show a hitmap bit and a delay of L-1, while the second shows no bit, a delay of L and a count of 0. A second collision is a channel edge landing in the same cycle that opens the window. That channel must report a delay of 0 and a count of 1.

// File: rtl/coinc_pkg.sv
// Shared types for the coincidence window evaluator.
// Assumes: two-bit requirement codes, four-state control sequence.
package coinc_pkg;
    typedef enum logic [1:0] {
        REQ_DONT = 2'b00,
        REQ_MUST = 2'b01,
        REQ_VETO = 2'b10,
        REQ_RSV  = 2'b11
    } req_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OPEN,
        ST_EVAL,
        ST_HOLD
    } state_e;
endpackage

// File: rtl/coinc_edge.sv
// Rising-edge detector for all hit lines, gated by the channel enables.
// Assumes: hit lines are already synchronous to clk.
module coinc_edge #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hit_i,
    input  logic [NCH-1:0] enable_i,
    output logic [NCH-1:0] edge_o
);
    logic [NCH-1:0] prev_q;

    // remember last sampled level of every hit line
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= hit_i;
    end

    assign edge_o = hit_i & ~prev_q & enable_i;
endmodule

// File: rtl/coinc_chan_tdc.sv
// One channel's recorder: fired flag, first-hit delay and accepted edge
// count. Assumes open_i and run_i are never high together.
module coinc_chan_tdc #(
    parameter int WIN_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic             run_i,
    input  logic             accept_i,
    input  logic             edge_i,
    output logic             fired_o,
    output logic [WIN_W-1:0] delay_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [WIN_W-1:0] DLY_MAX = {WIN_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             fired_q;
    logic [WIN_W-1:0] delay_q;
    logic [CNT_W-1:0] count_q;

    // restart on window open, then time and count until the window closes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fired_q <= 1'b0;
            delay_q <= '0;
            count_q <= '0;
        end else if (open_i) begin
            fired_q <= edge_i;
            delay_q <= '0;
            count_q <= {{(CNT_W-1){1'b0}}, edge_i};
        end else if (run_i) begin
            if (!fired_q && delay_q != DLY_MAX) delay_q <= delay_q + 1'b1;
            if (accept_i && edge_i) begin
                fired_q <= 1'b1;
                if (count_q != CNT_MAX) count_q <= count_q + 1'b1;
            end
        end
    end

    assign fired_o = fired_q;
    assign delay_o = delay_q;
    assign count_o = count_q;
endmodule

// File: rtl/coinc_ctrl.sv
// Window sequencer: idle, open, evaluate, hold-until-rearm. Captures the
// window length and requirement at open. Assumes win_len_i of 0 means 1.
module coinc_ctrl #(
    parameter int NCH   = 8,
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_edge_i,
    input  logic [WIN_W-1:0] win_len_i,
    input  logic [2*NCH-1:0] req_i,
    input  logic             rearm_i,
    output logic             open_o,
    output logic             run_o,
    output logic             accept_o,
    output logic             eval_o,
    output logic             busy_o,
    output logic [2*NCH-1:0] req_o
);
    import coinc_pkg::*;

    state_e           state_q;
    logic [WIN_W-1:0] wc_q;
    logic [WIN_W-1:0] len_q;
    logic [2*NCH-1:0] req_q;

    // advance the sequence and the elapsed-cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wc_q    <= '0;
            len_q   <= '0;
            req_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (any_edge_i) begin
                    state_q <= ST_OPEN;
                    wc_q    <= WIN_W'(1);
                    len_q   <= (win_len_i == '0) ? WIN_W'(1) : win_len_i;
                    req_q   <= req_i;
                end
                ST_OPEN: if (wc_q >= len_q) state_q <= ST_EVAL;
                         else               wc_q    <= wc_q + 1'b1;
                ST_EVAL: state_q <= ST_HOLD;
                default: if (rearm_i) state_q <= ST_IDLE;
            endcase
        end
    end

    // decode control strobes from the current state
    always_comb begin
        open_o   = (state_q == ST_IDLE) && any_edge_i;
        run_o    = (state_q == ST_OPEN);
        accept_o = run_o && (wc_q < len_q);
        eval_o   = (state_q == ST_EVAL);
        busy_o   = run_o || eval_o;
    end

    assign req_o = req_q;
endmodule

// File: rtl/coinc_match.sv
// Compares the fired vector with the per-channel two-bit requirement.
// Assumes codes 00 and 11 both mean "ignore".
module coinc_match #(
    parameter int NCH = 8
) (
    input  logic [2*NCH-1:0] req_i,
    input  logic [NCH-1:0]   fired_i,
    output logic             match_o
);
    import coinc_pkg::*;

    // every channel must satisfy its own code
    always_comb begin
        match_o = 1'b1;
        for (int c = 0; c < NCH; c++) begin
            case (req_e'(req_i[2*c +: 2]))
                REQ_MUST: if (!fired_i[c]) match_o = 1'b0;
                REQ_VETO: if (fired_i[c])  match_o = 1'b0;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/coinc_window_eval.sv
// Top: coincidence window evaluator with per-channel arrival timing and
// edge counts. Assumes synchronous hit lines and a rearm after each result.
module coinc_window_eval #(
    parameter int NCH   = 8,
    parameter int WIN_W = 16,
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCH-1:0]     hit_i,
    input  logic [NCH-1:0]     enable_i,
    input  logic [2*NCH-1:0]   req_i,
    input  logic [WIN_W-1:0]   win_len_i,
    input  logic               rearm_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               valid_o,
    output logic [NCH-1:0]     hitmap_o,
    output logic [NCH*WIN_W-1:0] delay_o,
    output logic [NCH*CNT_W-1:0] count_o
);
    logic [NCH-1:0]   edges;
    logic [NCH-1:0]   fired;
    logic [2*NCH-1:0] req_cap;
    logic             open_s, run_s, accept_s, eval_s, match_s;

    coinc_edge #(.NCH(NCH)) u_edge (
        .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .enable_i(enable_i),
        .edge_o(edges)
    );

    coinc_ctrl #(.NCH(NCH), .WIN_W(WIN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .any_edge_i(|edges),
        .win_len_i(win_len_i), .req_i(req_i), .rearm_i(rearm_i),
        .open_o(open_s), .run_o(run_s), .accept_o(accept_s),
        .eval_o(eval_s), .busy_o(busy_o), .req_o(req_cap)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        coinc_chan_tdc #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_tdc (
            .clk(clk), .rst_n(rst_n), .open_i(open_s), .run_i(run_s),
            .accept_i(accept_s), .edge_i(edges[c]), .fired_o(fired[c]),
            .delay_o(delay_o[c*WIN_W +: WIN_W]),
            .count_o(count_o[c*CNT_W +: CNT_W])
        );
    end

    coinc_match #(.NCH(NCH)) u_match (
        .req_i(req_cap), .fired_i(fired), .match_o(match_s)
    );

    assign done_o   = eval_s;
    assign valid_o  = eval_s && match_s;
    assign hitmap_o = fired;
endmodule

// File: rtl/coinc_window_eval_chk.sv
// Assertion checker for coinc_window_eval, attached with bind below.
// Assumes the same parameters as the bound instance.
module coinc_window_eval_chk #(
    parameter int NCH   = 8,
    parameter int WIN_W = 16,
    parameter int CNT_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NCH-1:0]       hit_i,
    input logic [NCH-1:0]       enable_i,
    input logic                 rearm_i,
    input logic                 busy_o,
    input logic                 done_o,
    input logic                 valid_o,
    input logic [NCH-1:0]       hitmap_o,
    input logic [NCH*WIN_W-1:0] delay_o,
    input logic [NCH*CNT_W-1:0] count_o
);
    logic [NCH-1:0] lvl_q;
    logic           hold_q;

    // checker's own view of previous levels and of the waiting phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            hold_q <= 1'b0;
        end else begin
            lvl_q <= hit_i;
            if (done_o)                 hold_q <= 1'b1;
            else if (hold_q && rearm_i) hold_q <= 1'b0;
        end
    end

    a_r1_open_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(|(hit_i & ~lvl_q & enable_i)));
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r8_valid_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> done_o);
    a_r8_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);
    a_r8_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
    a_r8_results_held: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> busy_o || $stable({hitmap_o, delay_o, count_o}));
    a_r9_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |=> !busy_o);
endmodule

bind coinc_window_eval coinc_window_eval_chk #(
    .NCH(NCH), .WIN_W(WIN_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .enable_i(enable_i),
    .rearm_i(rearm_i), .busy_o(busy_o), .done_o(done_o), .valid_o(valid_o),
    .hitmap_o(hitmap_o), .delay_o(delay_o), .count_o(count_o)
);

// File: tb/coinc_window_eval_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module coinc_window_eval_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   hit_i = '0;
    logic [7:0]   enable_i = '1;
    logic [15:0]  req_i = '0;
    logic [15:0]  win_len_i = 16'd8;
    logic         rearm_i = 1'b0;
    logic         busy_o, done_o, valid_o;
    logic [7:0]   hitmap_o;
    logic [127:0] delay_o;
    logic [63:0]  count_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [7:0]  pat [0:1023];
    logic [7:0]  en_v;
    logic [15:0] req_v, len_v;
    int          rearm_at;
    bit          chg_mid;
    logic [15:0] len_mid, req_mid;
    logic [7:0]  exp_fired;
    int          exp_delay [0:7];
    int          exp_cnt   [0:7];
    int          exp_start, exp_eff;
    bit          exp_valid;

    always #10 clk = ~clk;

    coinc_window_eval u_dut (
        .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .enable_i(enable_i),
        .req_i(req_i), .win_len_i(win_len_i), .rearm_i(rearm_i),
        .busy_o(busy_o), .done_o(done_o), .valid_o(valid_o),
        .hitmap_o(hitmap_o), .delay_o(delay_o), .count_o(count_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            summary();
        end
    end

    task automatic clr_pat();
        for (int i = 0; i < 1024; i++) pat[i] = '0;
        rearm_at = -1;
        chg_mid  = 0;
    endtask

    // reference expectation derived from the requirements
    task automatic model(input int n);
        logic [7:0] prv, e;
        bit op;
        op = 0; prv = '0; exp_start = 0;
        exp_eff = (len_v == 0) ? 1 : int'(len_v);
        exp_fired = '0;
        for (int c = 0; c < 8; c++) begin exp_delay[c] = 0; exp_cnt[c] = 0; end
        for (int t = 0; t < n; t++) begin
            e = pat[t] & ~prv & en_v;
            prv = pat[t];
            if (!op) begin
                if (e != 0) begin
                    op = 1; exp_start = t; exp_fired = e;
                    for (int c = 0; c < 8; c++) exp_cnt[c] = int'(e[c]);
                end
            end else if (t - exp_start < exp_eff) begin
                for (int c = 0; c < 8; c++) if (e[c]) begin
                    if (exp_cnt[c] < 255) exp_cnt[c]++;
                    if (!exp_fired[c]) begin exp_fired[c] = 1; exp_delay[c] = t - exp_start; end
                end
            end
        end
        exp_valid = 1;
        for (int c = 0; c < 8; c++) begin
            if (!exp_fired[c]) exp_delay[c] = exp_eff;
            if (req_v[2*c +: 2] == 2'b01 && !exp_fired[c]) exp_valid = 0;
            if (req_v[2*c +: 2] == 2'b10 &&  exp_fired[c]) exp_valid = 0;
        end
    endtask

    // play a pattern, wait for the result, compare all outputs, then rearm
    task automatic play(input int n, input string tag);
        int td;
        en_v = enable_i; req_v = req_i; len_v = win_len_i;
        model(n);
        td = -1;
        for (int t = 0; t < 3000; t++) begin
            hit_i   = (t < n) ? pat[t] : '0;
            rearm_i = (t == rearm_at);
            if (chg_mid && t == 1) begin win_len_i = len_mid; req_i = req_mid; end
            @(negedge clk);
            if (done_o) begin td = t + 1; break; end
        end
        hit_i = '0; rearm_i = 0;
        chk(td == exp_start + exp_eff + 1, {tag, " R2 done timing"}, td, exp_start + exp_eff + 1);
        chk(valid_o == exp_valid, {tag, " R4 verdict"}, valid_o, exp_valid);
        chk(hitmap_o == exp_fired, {tag, " R6 hitmap"}, hitmap_o, exp_fired);
        for (int c = 0; c < 8; c++) begin
            chk(int'(delay_o[16*c +: 16]) == exp_delay[c], {tag, " R3 delay"},
                delay_o[16*c +: 16], exp_delay[c]);
            chk(int'(count_o[8*c +: 8]) == exp_cnt[c], {tag, " R7 count"},
                count_o[8*c +: 8], exp_cnt[c]);
        end
        @(negedge clk);
        chk(!done_o && !busy_o, {tag, " R8 strobe ends"}, {done_o, busy_o}, 0);
    endtask

    task automatic rearm();
        rearm_i = 1; @(negedge clk); rearm_i = 0; @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!busy_o && !done_o && !valid_o, "R8 reset strobes", {busy_o, done_o, valid_o}, 0);
        chk(hitmap_o == 0 && count_o == 0, "R6 reset hitmap", hitmap_o, 0);
    endtask

    task automatic t_basic();
        clr_pat();
        enable_i = '1; win_len_i = 8; req_i = 16'h0011;
        pat[0] = 8'h01; pat[3] = 8'h04; pat[5] = 8'h01;
        play(8, "basic R3 R7");
        chk(valid_o == 0, "R8 valid only with done", valid_o, 0);
        rearm();
    endtask

    task automatic t_veto();
        clr_pat();
        enable_i = '1; win_len_i = 6; req_i = 16'h0009;
        pat[0] = 8'h01; pat[2] = 8'h02;
        play(4, "veto R4");
        rearm();
    endtask

    task automatic t_ignore_start();
        clr_pat();
        enable_i = '1; win_len_i = 5; req_i = 16'h0001;
        pat[0] = 8'h20; pat[2] = 8'h01;
        play(4, "ignore opens R5");
        chk(hitmap_o[5] == 1, "R5 ignored channel recorded", hitmap_o[5], 1);
        rearm();
    endtask

    task automatic t_boundary();
        clr_pat();
        enable_i = '1; win_len_i = 6; req_i = 16'h0040;
        pat[0] = 8'h01; pat[5] = 8'h08; pat[6] = 8'h10;
        play(8, "window edge R2");
        chk(int'(delay_o[16*3 +: 16]) == 5, "R2 last accepted index", delay_o[16*3 +: 16], 5);
        chk(hitmap_o[4] == 0, "R2 closing index rejected", hitmap_o[4], 0);
        rearm();
    endtask

    task automatic t_disabled();
        clr_pat();
        enable_i = 8'h7F; win_len_i = 4; req_i = 16'h0000;
        hit_i = 8'h80; @(negedge clk); hit_i = 0;
        repeat (3) @(negedge clk);
        chk(!busy_o, "R1 disabled channel opens nothing", busy_o, 0);
        pat[0] = 8'h02; pat[1] = 8'h80;
        play(3, "disabled R1");
        chk(hitmap_o[7] == 0, "R1 disabled channel not recorded", hitmap_o[7], 0);
        rearm();
        enable_i = '1;
    endtask

    task automatic t_long_len0();
        clr_pat();
        enable_i = '1; win_len_i = 0; req_i = 16'h0002;
        pat[0] = 8'h81; pat[1] = 8'h81; pat[2] = 8'h01;
        play(4, "len0 R10");
        chk(int'(count_o[0 +: 8]) == 1, "R10 held line counts once", count_o[0 +: 8], 1);
        chk(hitmap_o == 8'h81, "R6 channel 8 is MSB", hitmap_o, 8'h81);
        rearm();
    endtask

    task automatic t_saturate();
        clr_pat();
        enable_i = '1; win_len_i = 600; req_i = 16'h0004;
        for (int i = 0; i < 600; i += 2) pat[i] = 8'h02;
        play(600, "saturate R7");
        chk(count_o[8 +: 8] == 8'd255, "R7 count saturates", count_o[8 +: 8], 255);
        rearm();
    endtask

    task automatic t_capture();
        clr_pat();
        enable_i = '1; win_len_i = 5; req_i = 16'h0001;
        chg_mid = 1; len_mid = 40; req_mid = 16'h0002;
        pat[0] = 8'h01;
        play(2, "capture R11");
        chk(valid_o == 0, "R11 later code change ignored", valid_o, 0);
        rearm();
    endtask

    task automatic t_hold();
        logic [7:0] keep;
        clr_pat();
        enable_i = '1; win_len_i = 10; req_i = 16'h0000;
        pat[0] = 8'h04; rearm_at = 3;
        play(2, "early rearm R9");
        keep = hitmap_o;
        for (int i = 0; i < 5; i++) begin
            hit_i = (i % 2 == 0) ? 8'h03 : 8'h00;
            @(negedge clk);
        end
        hit_i = 0; @(negedge clk);
        chk(!busy_o, "R9 no window before rearm", busy_o, 0);
        chk(hitmap_o == keep, "R9 results held", hitmap_o, keep);
        rearm();
    endtask

    task automatic t_reserved();
        clr_pat();
        enable_i = '1; win_len_i = 3; req_i = 16'h000F;
        pat[0] = 8'h01;
        play(2, "reserved code R4");
        rearm();
    endtask

    task automatic t_held_rearm();
        clr_pat();
        enable_i = '1; win_len_i = 2; req_i = 16'h0000;
        pat[0] = 8'h01;
        play(2, "held R10");
        hit_i = 8'h08; @(negedge clk);
        rearm();
        repeat (3) @(negedge clk);
        chk(!busy_o, "R10 line high across rearm opens nothing", busy_o, 0);
        hit_i = 0; @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic();
        t_veto();
        t_ignore_start();
        t_boundary();
        t_disabled();
        t_long_len0();
        t_saturate();
        t_capture();
        t_hold();
        t_reserved();
        t_held_rearm();
        summary();
    end
endmodule